// File: doc/BRIEF.md
# Flag-Producing 16-bit ALU

This block is the arithmetic and logic datapath of a small 16-bit processor core. In one cycle it combines a destination operand and a source operand under a 5-bit operation code, and it produces a result word and a write-enable for that result. Alongside it sits a four-bit status register with carry, zero, sign and overflow flags. Each operation has its own rule for which of the four flags it rewrites. The flags it does not touch keep their previous value.

The result path is purely combinational. The flag register loads on a rising clock edge when `op_valid` is high, and only the flags selected by the current operation change. Compare and test operations only set flags and never request a write-back. Operand fetch, memory, branching, multiply and divide are handled elsewhere in the core and are not part of this block.

Top module: `flagalu`

## Requirements
- R1: Opcode 0x02 (add) gives `result` = dst + src mod 2^16. On the clock edge it sets carry to the unsigned carry-out. It sets overflow when both operands have the same sign bit and the result's sign bit differs from it. It sets zero when the result is 0 and sign to result bit 15.
- R2: Opcode 0x03 (subtract) and opcode 0x0C (compare) give `result` = dst - src mod 2^16. Both set carry to the unsigned borrow (dst < src). Both set overflow when the operand sign bits differ and the result sign differs from dst's sign. Both set zero and sign from the result.
- R3: Opcodes 0x04 (AND), 0x05 (OR) and 0x0B (test, an AND) give the bitwise result. They clear carry and overflow and set zero and sign from the result.
- R4: Opcode 0x06 (shift left) and opcode 0x07 (shift right) shift dst by the count in src and fill vacated bits with zeros. For a non-zero count, carry is the last bit shifted out. Overflow is result bit 15 XOR carry for a left shift, and the original dst bit 15 for a right shift. Zero and sign are left unchanged.
- R5: A shift count of 0 gives `result` = dst and leaves every flag unchanged. A count of 16 or more gives `result` = 0. At count 16 the carry is dst bit 0 for a left shift and dst bit 15 for a right shift. Above 16 the carry is 0.
- R6: Opcode 0x19 (negate) gives `result` = 0 - dst. Carry is set exactly when dst is non-zero. Overflow is set only when dst = 0x8000, and in that case the result equals the operand 0x8000. Zero and sign follow the result.
- R7: Opcode 0x1D (NOT) gives the one's complement of dst and changes no flag.
- R8: `wr_en` is high exactly when `op_valid` is high and the opcode is 0x02, 0x03, 0x04, 0x05, 0x06, 0x07, 0x19 or 0x1D. Any other opcode drives `result` to 0.
- R9: The flags change only on a clock edge with `op_valid` high. An opcode outside those listed in R1 to R7 changes no flag.
- R10: The flag register clears all four flags on a clock edge with `rst_n` low, even when `op_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the flag register |
| op_valid | input | 1 | Operation strobe; qualifies write-enable and flag update |
| opcode | input | 5 | Operation code |
| dst_in | input | 16 | Destination operand |
| src_in | input | 16 | Source operand or shift count |
| result | output | 16 | Combinational result word |
| wr_en | output | 1 | Result write-back request |
| carry | output | 1 | Registered carry / borrow flag |
| zero | output | 1 | Registered zero flag |
| sign | output | 1 | Registered sign flag |
| ovf | output | 1 | Registered overflow flag |

## Verification
The bench builds the block with its default width of 16 bits and 5-bit opcodes. At this width the signed limits 0x7FFF and 0x8000, and the shift counts 15, 16 and 17, can all be driven directly. A reference model of the flags lets the checks cover flags held over from earlier operations, not only the flags each operation rewrites. A random phase draws shift counts from a narrow range so that the zero-count and saturated-count cases occur often.

// File: rtl/flagalu_pkg.sv
// Shared opcode and flag-index definitions for the flag-producing ALU.
// Assumes a 5-bit opcode space; unlisted codes are treated as no-ops.
package flagalu_pkg;
    localparam int OPC_W = 5;
    localparam int NFLAG = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD  = 5'h02,
        OP_SUB  = 5'h03,
        OP_AND  = 5'h04,
        OP_OR   = 5'h05,
        OP_SHL  = 5'h06,
        OP_SHR  = 5'h07,
        OP_TEST = 5'h0B,
        OP_CMP  = 5'h0C,
        OP_NEG  = 5'h19,
        OP_NOT  = 5'h1D
    } alu_op_e;

    // Bit positions inside the internal flag vector
    localparam int FI_C = 3;
    localparam int FI_Z = 2;
    localparam int FI_S = 1;
    localparam int FI_O = 0;
endpackage

// File: rtl/flagalu_addsub.sv
// Adder/subtractor producing result, unsigned carry-or-borrow and signed overflow.
// Assumes x and y are already selected by the caller (negate uses x = 0).
module flagalu_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         sub,
    output logic [W-1:0] r,
    output logic         cy,
    output logic         v
);
    logic [W:0] wide;

    // Form the W+1 bit sum or difference; top bit is carry or borrow
    always_comb begin
        if (sub) wide = {1'b0, x} - {1'b0, y};
        else     wide = {1'b0, x} + {1'b0, y};
    end

    assign r  = wide[W-1:0];
    assign cy = wide[W];

    // Signed overflow: operand signs vs result sign
    always_comb begin
        if (sub) v = (x[W-1] != y[W-1]) && (r[W-1] != x[W-1]);
        else     v = (x[W-1] == y[W-1]) && (r[W-1] != x[W-1]);
    end
endmodule

// File: rtl/flagalu_shift.sv
// Logical shifter with zero fill, last-bit-out carry and saturated count.
// Assumes the count is unsigned and any value above W behaves as W+1.
module flagalu_shift #(
    parameter int W = 16
) (
    input  logic [W-1:0] d,
    input  logic [W-1:0] cnt,
    input  logic         left,
    output logic [W-1:0] r,
    output logic         cy,
    output logic         v,
    output logic         act
);
    localparam int CW = $clog2(W + 2);
    localparam logic [CW-1:0] SAT = CW'(W + 1);

    logic [CW-1:0]  cnt_s;
    logic [2*W-1:0] t;

    // Clamp the count so the shifter stays 2W wide
    always_comb begin
        if (cnt > W[W-1:0]) cnt_s = SAT;
        else                cnt_s = cnt[CW-1:0];
    end

    // Shift through a double-width window; the bit next to the window holds carry
    always_comb begin
        if (left) begin
            t  = {{W{1'b0}}, d} << cnt_s;
            r  = t[W-1:0];
            cy = t[W];
            v  = t[W-1] ^ t[W];
        end else begin
            t  = {d, {W{1'b0}}} >> cnt_s;
            r  = t[2*W-1:W];
            cy = t[W-1];
            v  = d[W-1];
        end
    end

    assign act = |cnt;
endmodule

// File: rtl/flagalu_flagreg.sv
// Status register with a per-flag update mask and synchronous active-low reset.
// Assumes mask and next values are stable before the clock edge.
module flagalu_flagreg #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd,
    input  logic [N-1:0] mask,
    input  logic [N-1:0] nxt,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // Each flag loads only when strobed and selected by the mask
        always_ff @(posedge clk) begin
            if (!rst_n)               q[i] <= 1'b0;
            else if (upd && mask[i])  q[i] <= nxt[i];
        end
    end
endmodule

// File: rtl/flagalu.sv
// Flag-producing ALU: decodes the opcode, selects a datapath result,
// derives write-enable and per-flag update mask, and holds the flags.
// Assumes operands are valid whenever op_valid is high.
module flagalu
    import flagalu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [OPC_W-1:0] opcode,
    input  logic [W-1:0]     dst_in,
    input  logic [W-1:0]     src_in,
    output logic [W-1:0]     result,
    output logic             wr_en,
    output logic             carry,
    output logic             zero,
    output logic             sign,
    output logic             ovf
);
    logic [W-1:0]     as_x, as_y, as_r, sh_r;
    logic             as_sub, as_c, as_v, sh_c, sh_v, sh_act, sh_left;
    logic             writes;
    logic [NFLAG-1:0] mask, nxt, fq;
    logic             nc, no;

    // Operand steering for the shared adder (negate is 0 - dst)
    always_comb begin
        as_x   = (opcode == OP_NEG) ? '0 : dst_in;
        as_y   = (opcode == OP_NEG) ? dst_in : src_in;
        as_sub = (opcode != OP_ADD);
    end

    assign sh_left = (opcode == OP_SHL);

    flagalu_addsub #(.W(W)) u_addsub (
        .x(as_x), .y(as_y), .sub(as_sub), .r(as_r), .cy(as_c), .v(as_v)
    );

    flagalu_shift #(.W(W)) u_shift (
        .d(dst_in), .cnt(src_in), .left(sh_left),
        .r(sh_r), .cy(sh_c), .v(sh_v), .act(sh_act)
    );

    // Opcode decode: result select, write-back and flag mask
    always_comb begin
        result = '0;
        writes = 1'b0;
        mask   = '0;
        nc     = 1'b0;
        no     = 1'b0;
        case (opcode)
            OP_ADD, OP_SUB, OP_NEG: begin
                result = as_r; writes = 1'b1;
                mask = '1; nc = as_c; no = as_v;
            end
            OP_CMP: begin
                result = as_r;
                mask = '1; nc = as_c; no = as_v;
            end
            OP_AND: begin
                result = dst_in & src_in; writes = 1'b1; mask = '1;
            end
            OP_OR: begin
                result = dst_in | src_in; writes = 1'b1; mask = '1;
            end
            OP_TEST: begin
                result = dst_in & src_in; mask = '1;
            end
            OP_SHL, OP_SHR: begin
                result = sh_r; writes = 1'b1;
                mask[FI_C] = sh_act; mask[FI_O] = sh_act;
                nc = sh_c; no = sh_v;
            end
            OP_NOT: begin
                result = ~dst_in; writes = 1'b1;
            end
            default: ;
        endcase
    end

    // Assemble next flag values; zero and sign always derive from result
    always_comb begin
        nxt       = '0;
        nxt[FI_C] = nc;
        nxt[FI_Z] = ~|result;
        nxt[FI_S] = result[W-1];
        nxt[FI_O] = no;
    end

    assign wr_en = op_valid & writes;

    flagalu_flagreg #(.N(NFLAG)) u_flags (
        .clk(clk), .rst_n(rst_n), .upd(op_valid),
        .mask(mask), .nxt(nxt), .q(fq)
    );

    assign carry = fq[FI_C];
    assign zero  = fq[FI_Z];
    assign sign  = fq[FI_S];
    assign ovf   = fq[FI_O];
endmodule

// File: rtl/flagalu_chk.sv
// Checker for the flag-producing ALU, attached by bind.
// Assumes the opcode encodings of flagalu_pkg.
module flagalu_chk
    import flagalu_pkg::*;
#(
    parameter int W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [OPC_W-1:0] opcode,
    input logic [W-1:0]     dst_in,
    input logic [W-1:0]     result,
    input logic             wr_en,
    input logic             carry,
    input logic             zero,
    input logic             sign,
    input logic             ovf
);
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    AST_IDLE_HOLDS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable({carry, zero, sign, ovf})); // R9
    AST_NOT_HOLDS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == OP_NOT) |=> $stable({carry, zero, sign, ovf})); // R7
    AST_LOGIC_CLEARS_CO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (opcode == OP_AND || opcode == OP_OR || opcode == OP_TEST))
        |=> (!carry && !ovf)); // R3
    AST_SHIFT_KEEPS_ZS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (opcode == OP_SHL || opcode == OP_SHR)) |=> $stable({zero, sign})); // R4
    AST_NO_WRITE_COMPARE: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_TEST || opcode == OP_CMP) |-> !wr_en); // R2
    AST_NEG_MIN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == OP_NEG && dst_in == MINV) |-> result == MINV); // R6
    AST_NEG_MIN_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == OP_NEG && dst_in == MINV) |=> ovf && carry); // R6
    AST_STROBE_GATES_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> !wr_en); // R8
endmodule

bind flagalu flagalu_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .dst_in(dst_in), .result(result), .wr_en(wr_en),
    .carry(carry), .zero(zero), .sign(sign), .ovf(ovf)
);

// File: tb/flagalu_tb.sv
// Self-checking bench: vector table, reference flag model, directed and random cases.
module flagalu_tb;
    localparam int W = 16;
    localparam int NV = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [4:0]   opcode = '0;
    logic [W-1:0] dst_in = '0, src_in = '0;
    logic [W-1:0] result;
    logic         wr_en, carry, zero, sign, ovf;

    int n_chk = 0;
    int n_fail = 0;
    logic [3:0] mf = 4'b0000; // model flags {c,z,s,o}

    // Table entry: {opcode, dst, src, expected result}
    localparam logic [52:0] VEC [NV] = '{
        {5'h02, 16'h7FFF, 16'h0001, 16'h8000},
        {5'h02, 16'hFFFF, 16'h0001, 16'h0000},
        {5'h03, 16'h0003, 16'h0005, 16'hFFFE},
        {5'h0C, 16'h8000, 16'h0001, 16'h7FFF},
        {5'h04, 16'hF0F0, 16'h0FF0, 16'h00F0},
        {5'h05, 16'h1200, 16'h0034, 16'h1234},
        {5'h0B, 16'h00FF, 16'hFF00, 16'h0000},
        {5'h06, 16'h8001, 16'h0001, 16'h0002},
        {5'h07, 16'h0003, 16'h0001, 16'h0001},
        {5'h06, 16'h1235, 16'h0010, 16'h0000},
        {5'h07, 16'hABCD, 16'h0000, 16'hABCD},
        {5'h19, 16'h0001, 16'h0000, 16'hFFFF},
        {5'h19, 16'h8000, 16'h0000, 16'h8000},
        {5'h19, 16'h0000, 16'h0000, 16'h0000},
        {5'h1D, 16'h00FF, 16'h0000, 16'hFF00},
        {5'h08, 16'h1234, 16'h5678, 16'h0000}
    };

    flagalu #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .dst_in(dst_in), .src_in(src_in), .result(result), .wr_en(wr_en),
        .carry(carry), .zero(zero), .sign(sign), .ovf(ovf)
    );

    always #2 clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string tag_of(logic [4:0] op);
        case (op)
            5'h02: return "R1";
            5'h03, 5'h0C: return "R2";
            5'h04, 5'h05, 5'h0B: return "R3";
            5'h06, 5'h07: return "R4";
            5'h19: return "R6";
            5'h1D: return "R7";
            default: return "R9";
        endcase
    endfunction

    // Reference model: returns {result, wr, new flags} from current model flags
    function automatic logic [20:0] model(logic [4:0] op, logic [15:0] d, logic [15:0] s,
                                          logic [3:0] f);
        logic [15:0] r = 16'h0;
        logic wr = 1'b0;
        logic c = f[3], z = f[2], sg = f[1], o = f[0];
        int n;
        case (op)
            5'h02: begin
                int sum = int'(d) + int'(s);
                r = sum[15:0]; wr = 1; c = sum > 65535;
                o = (d[15] == s[15]) && (r[15] != d[15]);
                z = (r == 0); sg = r[15];
            end
            5'h03, 5'h0C: begin
                r = d - s; wr = (op == 5'h03); c = d < s;
                o = (d[15] != s[15]) && (r[15] != d[15]);
                z = (r == 0); sg = r[15];
            end
            5'h04, 5'h05, 5'h0B: begin
                r = (op == 5'h05) ? (d | s) : (d & s); wr = (op != 5'h0B);
                c = 0; o = 0; z = (r == 0); sg = r[15];
            end
            5'h06, 5'h07: begin
                n = int'(s); wr = 1;
                if (n == 0) r = d;
                else if (op == 5'h06) begin
                    r = (n >= 16) ? 16'h0 : d << n;
                    c = (n <= 16) ? d[16-n] : 1'b0;
                    o = r[15] ^ c;
                end else begin
                    r = (n >= 16) ? 16'h0 : d >> n;
                    c = (n <= 16) ? d[n-1] : 1'b0;
                    o = d[15];
                end
            end
            5'h19: begin
                r = 16'h0 - d; wr = 1; c = (d != 0); o = (d == 16'h8000);
                z = (r == 0); sg = r[15];
            end
            5'h1D: begin r = ~d; wr = 1; end
            default: ;
        endcase
        return {r, wr, c, z, sg, o};
    endfunction

    // Drive one operation at a falling edge, check outputs, then flags after the edge
    task automatic run_op(logic [4:0] op, logic [15:0] d, logic [15:0] s,
                          bit has_exp, logic [15:0] exp_r);
        logic [20:0] m;
        string t;
        @(negedge clk);
        op_valid = 1; opcode = op; dst_in = d; src_in = s;
        m = model(op, d, s, mf);
        t = tag_of(op);
        #1;
        if (op == 5'h06 || op == 5'h07)
            if (s == 0 || s >= 16) t = "R5";
        check({t, " result"}, 32'(result), 32'(m[20:5]));
        if (has_exp) check({t, " table result"}, 32'(result), 32'(exp_r));
        check({"R8 wr_en ", t}, 32'(wr_en), 32'(m[4]));
        @(negedge clk);
        check({t, " flags"}, 32'({carry, zero, sign, ovf}), 32'(m[3:0]));
        mf = m[3:0];
        op_valid = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [4:0] ops [10] = '{5'h02, 5'h03, 5'h04, 5'h05, 5'h06,
                                 5'h07, 5'h0B, 5'h0C, 5'h19, 5'h1D};
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R10 reset flags", 32'({carry, zero, sign, ovf}), 32'h0);

        for (int i = 0; i < NV; i++)
            run_op(VEC[i][52:48], VEC[i][47:32], VEC[i][31:16], 1'b1, VEC[i][15:0]);

        // R5: saturated shift counts at 16 and 17
        run_op(5'h07, 16'h8000, 16'd16, 1'b1, 16'h0000);
        run_op(5'h06, 16'hFFFF, 16'd17, 1'b1, 16'h0000);
        run_op(5'h06, 16'h0001, 16'd15, 1'b1, 16'h8000);
        // R7: NOT with non-trivial flags held
        run_op(5'h02, 16'hFFFF, 16'h0001, 1'b0, 16'h0);
        run_op(5'h1D, 16'h0000, 16'h0000, 1'b1, 16'hFFFF);

        // R9: strobe low, add that would change flags
        @(negedge clk);
        op_valid = 0; opcode = 5'h02; dst_in = 16'h7FFF; src_in = 16'h0001;
        #1 check("R8 wr_en idle", 32'(wr_en), 32'h0);
        @(negedge clk);
        check("R9 flags idle", 32'({carry, zero, sign, ovf}), 32'(mf));

        // R10: reset wins over a strobed operation
        run_op(5'h19, 16'h8000, 16'h0, 1'b0, 16'h0);
        @(negedge clk);
        rst_n = 0; op_valid = 1; opcode = 5'h03; dst_in = 16'h0; src_in = 16'h1;
        @(negedge clk);
        check("R10 reset under strobe", 32'({carry, zero, sign, ovf}), 32'h0);
        rst_n = 1; op_valid = 0; mf = 4'b0000;

        // Random phase over all opcodes
        for (int k = 0; k < 400; k++) begin
            logic [4:0]  op = ops[$urandom_range(0, 9)];
            logic [15:0] d = 16'($urandom);
            logic [15:0] s = (op == 5'h06 || op == 5'h07) && k[0] ?
                             16'($urandom_range(0, 18)) : 16'($urandom);
            if (k % 7 == 0) d = 16'h8000;
            run_op(op, d, s, 1'b0, 16'h0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule